// File: doc/BRIEF.md
# Embedded Sync Decoder for 8-bit Digital Video

This block watches a byte-wide digital video stream whose line and field timing travels inside the data as four-byte timing reference codes. It finds each all-ones, all-zeros, all-zeros preamble and reads the status byte that follows. From that byte it takes the field, vertical-blank and horizontal flags. The resulting three-bit code is looked up in a per-field table of four boundary codes: active line start, active line end, blank line start and blank line end. The result drives the field identifier, a line-valid window, a per-sample pixel-valid strobe and a frame-start pulse.

The code table comes from one of two fixed presets for 625-line and 525-line interlaced video with 720 active samples per line, or from two configuration ports. In the two presets the same pair of code sets is assigned to the fields in opposite order. A mode input selects interlaced or progressive framing. A separate enable turns on checking of the four protection bits. This check is normally on for interlaced streams and off for plain progressive 8-bit streams.

Top module: `emb_sync_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `frame_start`, `field_id`, `line_valid`, `pix_valid` and `code_err` are 0.
- R2: A byte is taken as a status byte only when the three bytes before it were exactly 0xFF, 0x00, 0x00. In the status byte, bit 6 is the field flag F, bit 5 is the vertical flag V, bit 4 is the horizontal flag H, and bits 3..0 are protection bits. The lookup code is {H,V,F}, with H as its most significant bit.
- R3: `cfg_std` = 1 selects the first preset. Field 0 uses blank end 6, blank start 2, active end 4 and active start 0. Field 1 uses 7, 3, 5 and 1. `cfg_std` = 2 assigns the same two sets the other way round. `cfg_std` = 0 or 3 takes the field 0 set from `cfg_set0` and the field 1 set from `cfg_set1`, each packed as [11:9] blank end, [8:6] blank start, [5:3] active end, [2:0] active start. When a code matches both fields, field 0 wins.
- R4: `field_id` takes the field of every accepted matching code in the cycle after its status byte. `line_valid` rises after an accepted active-start code whose V flag is 0. Any other accepted matching code clears it.
- R5: `pix_data` is the input sample delayed by one cycle. `pix_valid` is 1 alongside it when `line_valid` was high as the sample arrived and the sample is neither all-ones, all-zeros, nor a status byte.
- R6: With `cfg_interlaced` = 1, `frame_start` pulses for one cycle when an accepted code moves `field_id` from 1 to 0. A move from 0 to 1 does not pulse it.
- R7: With `cfg_interlaced` = 0, `frame_start` pulses for one cycle when an accepted code has V = 0 and the previous accepted code had V = 1.
- R8: With `cfg_err_en` = 1, a status byte whose protection bits differ from {V^H, F^H, F^V, F^V^H} raises `code_err` for one cycle after it. That code changes neither `field_id` nor `line_valid`.
- R9: With `cfg_err_en` = 0, `code_err` stays 0, and a code with wrong protection bits is used like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one byte per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DATA_W | Incoming video sample |
| cfg_std | input | 2 | Code table source: 0/3 ports, 1 first preset, 2 swapped preset |
| cfg_interlaced | input | 1 | 1 interlaced framing, 0 progressive |
| cfg_err_en | input | 1 | Enables protection-bit checking |
| cfg_set0 | input | 12 | Field 0 boundary codes for the port table |
| cfg_set1 | input | 12 | Field 1 boundary codes for the port table |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |
| field_id | output | 1 | Current field |
| line_valid | output | 1 | Active-line window |
| pix_valid | output | 1 | Qualifies `pix_data` as an active pixel |
| pix_data | output | DATA_W | Sample delayed by one cycle |
| code_err | output | 1 | One-cycle pulse for a status byte that fails protection |

## Verification
The hardest situation to reach is a protection failure that lands in the middle of an active line. The bench has to show that the bad code leaves the line open, and that the pixel after it is still marked valid. The stimulus table opens a field 0 line and then sends an end code with one protection bit flipped. It checks the error pulse together with an unchanged `line_valid`, and then checks that the next sample is marked as a pixel. A custom table that maps an active-start code with V set forces the V qualification. A near-miss preamble checks that the match requires the exact three-byte sequence.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;

   typedef enum logic [1:0] {
      STD_PORTS = 2'd0,
      STD_PRE_A = 2'd1,
      STD_PRE_B = 2'd2,
      STD_ALT   = 2'd3
   } std_sel_e;

   typedef enum logic [2:0] {
      EVT_NONE,
      EVT_ACT_START,
      EVT_ACT_END,
      EVT_BLK_START,
      EVT_BLK_END
   } evt_e;

   // Packed as [11:9] blank end, [8:6] blank start, [5:3] active end, [2:0] active start
   typedef struct packed {
      logic [2:0] blk_end;
      logic [2:0] blk_start;
      logic [2:0] act_end;
      logic [2:0] act_start;
   } code_set_t;

   localparam code_set_t SET_EVEN = '{blk_end: 3'd6, blk_start: 3'd2, act_end: 3'd4, act_start: 3'd0};
   localparam code_set_t SET_ODD  = '{blk_end: 3'd7, blk_start: 3'd3, act_end: 3'd5, act_start: 3'd1};

   function automatic logic [3:0] prot_of(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/emb_sync_hunt.sv
module emb_sync_hunt
   import emb_sync_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic              hit,
   output logic              f_bit,
   output logic              v_bit,
   output logic              h_bit,
   output logic              prot_ok,
   output logic              reserved
);
   localparam int TOP = DATA_W - 1;

   logic [DATA_W-1:0] hist0, hist1, hist2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist0 <= '0;
         hist1 <= '0;
         hist2 <= '0;
      end else begin
         hist2 <= hist1;
         hist1 <= hist0;
         hist0 <= din;
      end
   end

   // Exact all-ones / zero / zero preamble in the three previous samples
   assign hit      = (&hist2) && !(|hist1) && !(|hist0);
   assign f_bit    = din[TOP-1];
   assign v_bit    = din[TOP-2];
   assign h_bit    = din[TOP-3];
   assign prot_ok  = (din[TOP-4 -: 4] == prot_of(f_bit, v_bit, h_bit));
   assign reserved = (&din) || !(|din);

endmodule

// File: rtl/emb_sync_classify.sv
module emb_sync_classify
   import emb_sync_pkg::*;
#(
   parameter int NFIELD = 2
) (
   input  code_set_t  set0,
   input  code_set_t  set1,
   input  logic [2:0] code,
   output logic       matched,
   output evt_e       evt,
   output logic       fld
);
   localparam int FW = (NFIELD > 1) ? $clog2(NFIELD) : 1;

   code_set_t sets  [NFIELD];
   evt_e      f_evt [NFIELD];

   assign sets[0] = set0;
   assign sets[1] = set1;

   for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
      always_comb begin
         if (code == sets[gi].act_start)      f_evt[gi] = EVT_ACT_START;
         else if (code == sets[gi].act_end)   f_evt[gi] = EVT_ACT_END;
         else if (code == sets[gi].blk_start) f_evt[gi] = EVT_BLK_START;
         else if (code == sets[gi].blk_end)   f_evt[gi] = EVT_BLK_END;
         else                                 f_evt[gi] = EVT_NONE;
      end
   end

   // Walk from the highest field down so field 0 has the last word
   always_comb begin
      logic [FW-1:0] sel;
      matched = 1'b0;
      evt     = EVT_NONE;
      sel     = '0;
      for (int fi = NFIELD - 1; fi >= 0; fi--) begin
         if (f_evt[fi] != EVT_NONE) begin
            matched = 1'b1;
            evt     = f_evt[fi];
            sel     = FW'(fi);
         end
      end
      fld = sel[0];
   end

endmodule

// File: rtl/emb_sync_timing.sv
module emb_sync_timing
   import emb_sync_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              hit,
   input  logic              v_bit,
   input  logic              prot_ok,
   input  logic              reserved,
   input  logic              matched,
   input  evt_e              evt,
   input  logic              fld,
   input  logic              cfg_interlaced,
   input  logic              cfg_err_en,
   output logic              frame_start,
   output logic              field_id,
   output logic              line_valid,
   output logic              pix_valid,
   output logic [DATA_W-1:0] pix_data,
   output logic              code_err
);
   logic accept;
   logic v_last;

   assign accept = hit && !(cfg_err_en && !prot_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_start <= 1'b0;
         field_id    <= 1'b0;
         line_valid  <= 1'b0;
         pix_valid   <= 1'b0;
         pix_data    <= '0;
         code_err    <= 1'b0;
         v_last      <= 1'b0;
      end else begin
         frame_start <= 1'b0;
         code_err    <= hit && cfg_err_en && !prot_ok;
         pix_data    <= din;
         pix_valid   <= line_valid && !hit && !reserved;
         if (accept) begin
            v_last <= v_bit;
            if (!cfg_interlaced && v_last && !v_bit) frame_start <= 1'b1;
            if (matched) begin
               field_id   <= fld;
               line_valid <= (evt == EVT_ACT_START) && !v_bit;
               if (cfg_interlaced && field_id && !fld) frame_start <= 1'b1;
            end
         end
      end
   end

   assert_fs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   assert_pix_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> line_valid);
   assert_pix_not_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_data != '0 && pix_data != '1));
   assert_err_no_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |-> ($stable(field_id) && $stable(line_valid)));
   assert_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |-> $past(cfg_err_en));

endmodule

// File: rtl/emb_sync_decoder.sv
module emb_sync_decoder
   import emb_sync_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        cfg_std,
   input  logic              cfg_interlaced,
   input  logic              cfg_err_en,
   input  logic [11:0]       cfg_set0,
   input  logic [11:0]       cfg_set1,
   output logic              frame_start,
   output logic              field_id,
   output logic              line_valid,
   output logic              pix_valid,
   output logic [DATA_W-1:0] pix_data,
   output logic              code_err
);
   localparam int NFIELD = 2;

   if (DATA_W < 8) begin : g_bad_width
      $error("emb_sync_decoder: DATA_W must be at least 8");
   end

   code_set_t  set0, set1;
   logic       hit, f_bit, v_bit, h_bit, prot_ok, reserved;
   logic       matched, fld;
   evt_e       evt;

   always_comb begin
      case (cfg_std)
         STD_PRE_A: begin set0 = SET_EVEN; set1 = SET_ODD;  end
         STD_PRE_B: begin set0 = SET_ODD;  set1 = SET_EVEN; end
         default:   begin set0 = code_set_t'(cfg_set0); set1 = code_set_t'(cfg_set1); end
      endcase
   end

   emb_sync_hunt #(.DATA_W(DATA_W)) u_hunt (
      .clk(clk), .rst_n(rst_n), .din(din), .hit(hit),
      .f_bit(f_bit), .v_bit(v_bit), .h_bit(h_bit),
      .prot_ok(prot_ok), .reserved(reserved)
   );

   emb_sync_classify #(.NFIELD(NFIELD)) u_classify (
      .set0(set0), .set1(set1), .code({h_bit, v_bit, f_bit}),
      .matched(matched), .evt(evt), .fld(fld)
   );

   emb_sync_timing #(.DATA_W(DATA_W)) u_timing (
      .clk(clk), .rst_n(rst_n), .din(din), .hit(hit), .v_bit(v_bit),
      .prot_ok(prot_ok), .reserved(reserved), .matched(matched),
      .evt(evt), .fld(fld), .cfg_interlaced(cfg_interlaced),
      .cfg_err_en(cfg_err_en), .frame_start(frame_start),
      .field_id(field_id), .line_valid(line_valid), .pix_valid(pix_valid),
      .pix_data(pix_data), .code_err(code_err)
   );

endmodule

// File: tb/emb_sync_decoder_bench.sv
module emb_sync_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = 8'h00;
   logic [1:0] cfg_std = 2'd1;
   logic       cfg_interlaced = 1'b1;
   logic       cfg_err_en = 1'b1;
   logic [11:0] cfg_set0 = '0;
   logic [11:0] cfg_set1 = '0;
   logic       frame_start, field_id, line_valid, pix_valid, code_err;
   logic [7:0] pix_data;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   emb_sync_decoder u_emb_sync_decoder (
      .clk(clk), .rst_n(rst_n), .din(din), .cfg_std(cfg_std),
      .cfg_interlaced(cfg_interlaced), .cfg_err_en(cfg_err_en),
      .cfg_set0(cfg_set0), .cfg_set1(cfg_set1),
      .frame_start(frame_start), .field_id(field_id),
      .line_valid(line_valid), .pix_valid(pix_valid),
      .pix_data(pix_data), .code_err(code_err)
   );

   // {sample, pix_valid, line_valid, field_id, frame_start, code_err}
   localparam int NV = 35;
   localparam logic [12:0] VEC [NV] = '{
      {8'hFF, 5'b00000}, {8'h00, 5'b00000}, {8'h00, 5'b00000},
      {8'hEC, 5'b00100}, {8'h55, 5'b00100},
      {8'hFF, 5'b00100}, {8'h00, 5'b00100}, {8'h00, 5'b00100},
      {8'hC7, 5'b01100}, {8'h10, 5'b11100}, {8'h20, 5'b11100},
      {8'hFF, 5'b01100}, {8'h00, 5'b01100}, {8'h00, 5'b01100},
      {8'hDA, 5'b00100},
      {8'hFF, 5'b00100}, {8'h00, 5'b00100}, {8'h00, 5'b00100},
      {8'h80, 5'b01010}, {8'h7F, 5'b11000},
      {8'hFF, 5'b01000}, {8'h00, 5'b01000}, {8'h00, 5'b01000},
      {8'h9C, 5'b01001}, {8'h33, 5'b11000},
      {8'hFF, 5'b01000}, {8'h00, 5'b01000}, {8'h00, 5'b01000},
      {8'h9D, 5'b00000}, {8'h44, 5'b00000},
      {8'hFF, 5'b00000}, {8'h01, 5'b00000}, {8'h00, 5'b00000},
      {8'h00, 5'b00000}, {8'h80, 5'b00000}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [7:0] b);
      din = b;
      @(negedge clk);
   endtask

   task automatic preamble();
      step(8'hFF); step(8'h00); step(8'h00);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      din = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [4:0] outs();
      return {pix_valid, line_valid, field_id, frame_start, code_err};
   endfunction

   initial begin
      do_reset();
      chk("R1 reset outputs", {27'd0, outs()}, 32'd0);

      // Table walk: first preset, interlaced, protection check on
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][12:5]);
         chk($sformatf("R2 R4 R5 R6 R8 vector %0d", i), {27'd0, outs()}, {27'd0, VEC[i][4:0]});
      end
      chk("R5 pix_data delay", {24'd0, pix_data}, 32'h80);

      // Swapped preset
      cfg_std = 2'd2;
      do_reset();
      preamble(); step(8'h80);
      chk("R3 swapped preset code 0 -> field 1", {27'd0, outs()}, {27'd0, 5'b01100});
      step(8'h12);
      chk("R5 pixel in swapped line", {31'd0, pix_valid}, 32'd1);
      preamble(); step(8'hC7);
      chk("R3 R6 swapped code 1 -> field 0 frame start", {27'd0, outs()}, {27'd0, 5'b01010});
      step(8'h12);
      chk("R6 frame start one cycle", {31'd0, frame_start}, 32'd0);

      // Progressive, protection check off
      cfg_std = 2'd1; cfg_interlaced = 1'b0; cfg_err_en = 1'b0;
      do_reset();
      preamble(); step(8'hAB);
      chk("R7 blank code no frame start", {27'd0, outs()}, {27'd0, 5'b00000});
      preamble(); step(8'h81);
      chk("R7 R9 V fall frame start, bad protection used", {27'd0, outs()}, {27'd0, 5'b01010});
      step(8'h22);
      chk("R9 R5 line open after unchecked code", {27'd0, outs()}, {27'd0, 5'b11000});

      // Port table: field0 {be6,bs7,ae4,as2}, field1 {be5,bs3,ae1,as0}; interlaced
      cfg_std = 2'd0; cfg_interlaced = 1'b1; cfg_err_en = 1'b1;
      cfg_set0 = {3'd6, 3'd7, 3'd4, 3'd2};
      cfg_set1 = {3'd5, 3'd3, 3'd1, 3'd0};
      do_reset();
      preamble(); step(8'hAB);
      chk("R4 active start with V set keeps line closed", {27'd0, outs()}, {27'd0, 5'b00000});
      preamble(); step(8'h80);
      chk("R3 port table code 0 -> field 1", {27'd0, outs()}, {27'd0, 5'b01100});
      preamble(); step(8'h9D);
      chk("R3 R6 port table code 4 -> field 0", {27'd0, outs()}, {27'd0, 5'b00010});

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule